// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides, once per reset, where the CPU clock comes from and then watches over the phase-locked loop. A three-bit strap value is sampled on every clock edge while reset is held low. The value seen at the last edge of reset picks one of three modes:

- the oscillator feeds the CPU directly;
- the oscillator is halved through a toggling clock enable;
- the PLL output is multiplied from the oscillator.

The block drives the PLL enable, the control that connects the oscillator reference to the PLL, and a select toward the PLL output. It also produces the CPU clock enable.

A lock indication from the analog loop arrives asynchronously. It is resynchronised and exposed as status. In PLL mode, a loss of lock raises a sticky interrupt request that software clears with a write-one strobe. If the loop is unlocked right after reset, the reference path is cut for good, and the CPU keeps running on the loop's free-running frequency. A lock-timeout flag reports a loop that has not locked within a parameterised number of cycles.

In the two oscillator modes the PLL is kept alive at its base frequency so that it can clock an oscillator watchdog. This holds unless the watchdog-disable input is high, in which case the PLL is switched off.

Top module: `clkmode_ctrl`

## Requirements
- R1: `mode_o` is taken from `strap_i` at each clock edge while `rst_n` is low and stays unchanged after release whatever `strap_i` does, until the next reset.
- R2: Strap 3'b011 selects direct mode (`mode_o` = 2'b01): `cpu_sel_pll_o` is 0 and `cpu_clk_en_o` is 1 in every cycle after the first edge out of reset.
- R3: Strap 3'b001 selects half-rate mode (`mode_o` = 2'b10): `cpu_clk_en_o` is 1 in the first cycle after release and alternates 0,1,0,... from then on.
- R4: Any other strap selects PLL mode (`mode_o` = 2'b00): `cpu_sel_pll_o` is 1 and `cpu_clk_en_o` is 1 after the first edge out of reset.
- R5: `pll_en_o` is 1 in PLL mode; in the two oscillator modes it equals the inverse of `wdog_off_i`.
- R6: `lock_o` equals `lock_async_i` as sampled two rising edges earlier, including during reset.
- R7: In PLL mode, a 1-to-0 change of `lock_o` sets `unlock_irq_o` one cycle later; in the oscillator modes `unlock_irq_o` stays 0.
- R8: `unlock_irq_o` stays set until a cycle with `irq_clr_i` high and no new unlock event; when both occur at the same edge, the set wins.
- R9: In PLL mode, if `lock_o` is 0 in the first cycle after release, `ref_conn_o` drops at the next edge and stays 0 until reset, even once lock appears; `ref_conn_o` is 0 in the oscillator modes.
- R10: In PLL mode, `lock_tmo_o` rises once `LOCK_TMO` post-reset cycles have passed with `lock_o` never high, and then stays high until reset; it never rises if `lock_o` was high earlier.
- R11: `cpu_clk_en_o` and `unlock_irq_o` are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_i | input | 3 | Mode strap value |
| wdog_off_i | input | 1 | Turns the PLL off in the oscillator modes |
| lock_async_i | input | 1 | Asynchronous lock indication from the loop |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the unlock request |
| pll_en_o | output | 1 | PLL enable |
| ref_conn_o | output | 1 | Connects the oscillator reference to the PLL input |
| cpu_sel_pll_o | output | 1 | Selects the PLL output as CPU clock source |
| cpu_clk_en_o | output | 1 | CPU clock enable in the oscillator domain |
| unlock_irq_o | output | 1 | Sticky unlock interrupt request |
| lock_tmo_o | output | 1 | Lock timeout status |
| mode_o | output | 2 | Latched mode: 00 PLL, 01 direct, 10 half-rate |
| lock_o | output | 1 | Synchronised lock status |

## Verification
A fresh unlock event and the software clear strobe can meet at the same edge. When they do, the request must survive that edge and only fall at a later clear. The bench provokes this by holding `irq_clr_i` high over several cycles around a lock drop, so that the set edge falls inside the clear window. Its cycle model, which gives the set priority, decides the expected request value on every edge. A second overlap is also covered: an unlock right after release coincides with the timeout count starting. The bench checks that the reference cut and the later timeout flag are each judged on their own.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int LOCK_TMO = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       wdog_off_i,
  input  logic       lock_async_i,
  input  logic       irq_clr_i,
  output logic       pll_en_o,
  output logic       ref_conn_o,
  output logic       cpu_sel_pll_o,
  output logic       cpu_clk_en_o,
  output logic       unlock_irq_o,
  output logic       lock_tmo_o,
  output logic [1:0] mode_o,
  output logic       lock_o
);
  localparam int CW = $clog2(LOCK_TMO + 1);
  localparam logic [1:0] M_PLL = 2'b00;
  localparam logic [1:0] M_DIR = 2'b01;
  localparam logic [1:0] M_DIV = 2'b10;

  logic [1:0]    mode_q;
  logic          sync1_q, lock_q, lock_prev_q;
  logic          run_q, div_q, first_q, cut_q, pend_q, seen_q;
  logic [CW-1:0] cnt_q;
  logic          is_pll, drop;

  assign is_pll = (mode_q == M_PLL);
  assign drop   = is_pll & lock_prev_q & ~lock_q;

  always_ff @(posedge clk) begin
    sync1_q <= lock_async_i;
    lock_q  <= sync1_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= (strap_i == 3'b011) ? M_DIR :
                     (strap_i == 3'b001) ? M_DIV : M_PLL;
      run_q       <= 1'b0;
      div_q       <= 1'b0;
      first_q     <= 1'b1;
      cut_q       <= 1'b0;
      pend_q      <= 1'b0;
      seen_q      <= 1'b0;
      cnt_q       <= '0;
      lock_prev_q <= lock_q;
    end else begin
      run_q       <= 1'b1;
      div_q       <= ~div_q;
      first_q     <= 1'b0;
      lock_prev_q <= lock_q;
      if (first_q && is_pll && !lock_q) cut_q <= 1'b1;
      pend_q <= drop | (pend_q & ~irq_clr_i);
      if (lock_q) seen_q <= 1'b1;
      else if (is_pll && !seen_q && cnt_q != CW'(LOCK_TMO)) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mode_o        = mode_q;
  assign lock_o        = lock_q;
  assign cpu_sel_pll_o = is_pll;
  assign pll_en_o      = is_pll | ~wdog_off_i;
  assign ref_conn_o    = is_pll & ~cut_q;
  assign cpu_clk_en_o  = (mode_q == M_DIV) ? div_q : run_q;
  assign unlock_irq_o  = pend_q;
  assign lock_tmo_o    = (cnt_q == CW'(LOCK_TMO));
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdog_off_i,
  input logic       irq_clr_i,
  input logic       pll_en_o,
  input logic       ref_conn_o,
  input logic       cpu_sel_pll_o,
  input logic       cpu_clk_en_o,
  input logic       unlock_irq_o,
  input logic       lock_tmo_o,
  input logic [1:0] mode_o,
  input logic       lock_o
);
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_o));
  p_direct_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_o == 2'b01) |-> (cpu_clk_en_o && !cpu_sel_pll_o));
  p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_o == 2'b10) |=> (cpu_clk_en_o != $past(cpu_clk_en_o)));
  p_pll_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (cpu_sel_pll_o && pll_en_o));
  p_wdog_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00 && wdog_off_i) |-> !pll_en_o);
  p_unlock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && $fell(lock_o)) |=> unlock_irq_o);
  p_no_irq_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00) |-> !unlock_irq_o);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_irq_o && !irq_clr_i) |=> unlock_irq_o);
  p_cut_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ref_conn_o) |=> !ref_conn_o);
  p_tmo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tmo_o |=> lock_tmo_o);
  p_quiet_reset_r11: assert property (@(posedge clk)
    (!rst_n && !$past(rst_n) && $past(rst_n, 2) == 1'b0) |-> (!cpu_clk_en_o && !unlock_irq_o));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wdog_off_i(wdog_off_i), .irq_clr_i(irq_clr_i),
  .pll_en_o(pll_en_o), .ref_conn_o(ref_conn_o), .cpu_sel_pll_o(cpu_sel_pll_o),
  .cpu_clk_en_o(cpu_clk_en_o), .unlock_irq_o(unlock_irq_o), .lock_tmo_o(lock_tmo_o),
  .mode_o(mode_o), .lock_o(lock_o)
);

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
  localparam int CLK_P = 10;
  localparam int TMO   = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap = 3'b011;
  logic wdog_off = 1'b0, lock_in = 1'b0, clr = 1'b0;
  logic pll_en, ref_conn, sel_pll, clk_en, irq, tmo, lock_s;
  logic [1:0] mode;

  int total = 0, bad = 0, cyc = 0;
  bit armed = 0;

  bit lq[$];
  int m_mode, m_run, m_div, m_first, m_cut, m_pend, m_seen, m_cnt, m_prev, m_lock;

  clkmode_ctrl #(.LOCK_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .wdog_off_i(wdog_off),
    .lock_async_i(lock_in), .irq_clr_i(clr), .pll_en_o(pll_en), .ref_conn_o(ref_conn),
    .cpu_sel_pll_o(sel_pll), .cpu_clk_en_o(clk_en), .unlock_irq_o(irq),
    .lock_tmo_o(tmo), .mode_o(mode), .lock_o(lock_s)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model, updated at each rising edge
  always @(posedge clk) begin
    int old_lock;
    bit pll;
    cyc++;
    old_lock = m_lock;
    pll = (m_mode == 0);
    if (!rst_n) begin
      m_mode  = (strap == 3'd3) ? 1 : (strap == 3'd1) ? 2 : 0;
      m_run = 0; m_div = 0; m_first = 1; m_cut = 0; m_pend = 0;
      m_seen = 0; m_cnt = 0; m_prev = old_lock;
    end else begin
      if (m_first == 1 && pll && old_lock == 0) m_cut = 1;
      m_first = 0;
      m_run = 1;
      m_div = 1 - m_div;
      m_pend = ((pll && m_prev == 1 && old_lock == 0) || (m_pend == 1 && !clr)) ? 1 : 0;
      m_prev = old_lock;
      if (old_lock == 1) m_seen = 1;
      else if (pll && m_seen == 0 && m_cnt < TMO) m_cnt++;
    end
    lq.push_front(lock_in);
    if (lq.size() > 2) void'(lq.pop_back());
    m_lock = (lq.size() == 2) ? int'(lq[1]) : 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (armed) begin
      chk("R1 mode", mode, m_mode);
      chk(m_mode == 0 ? "R4 sel" : "R2 sel", sel_pll, m_mode == 0);
      chk(m_mode == 2 ? "R3 clk_en" : "R11/R2/R4 clk_en", clk_en,
          (m_mode == 2) ? m_div : m_run);
      chk("R5 pll_en", pll_en, (m_mode == 0) ? 1 : int'(!wdog_off));
      chk("R6 lock", lock_s, m_lock);
      chk("R9 ref_conn", ref_conn, (m_mode == 0 && m_cut == 0) ? 1 : 0);
      chk("R7/R8 irq", irq, m_pend);
      chk("R10 tmo", tmo, m_cnt == TMO);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] s, input logic lk);
    @(negedge clk);
    rst_n = 1'b0; strap = s; lock_in = lk;
    cycles(4);
    rst_n = 1'b1;
  endtask

  initial begin
    // direct mode, watchdog on/off, strap changes after release (R1 R2 R5)
    do_reset(3'b011, 1'b0);
    armed = 1;
    cycles(5);
    strap = 3'b000; wdog_off = 1'b1;
    cycles(5);
    lock_in = 1'b1; cycles(3); lock_in = 1'b0; cycles(5);
    chk("R1 strap ignored", mode, 1);
    wdog_off = 1'b0;

    // half-rate mode, unlock ignored (R3 R7)
    do_reset(3'b001, 1'b1);
    cycles(6);
    lock_in = 1'b0; cycles(6);
    chk("R7 no irq in half-rate", irq, 0);
    wdog_off = 1'b1; cycles(4); wdog_off = 1'b0;

    // PLL mode locked at reset; unlock, clear, set-vs-clear collision (R4 R6 R7 R8)
    do_reset(3'b000, 1'b1);
    cycles(8);
    lock_in = 1'b0; cycles(6);
    chk("R8 sticky", irq, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0; cycles(2);
    chk("R8 cleared", irq, 0);
    lock_in = 1'b1; cycles(5);
    lock_in = 1'b0; clr = 1'b1;
    cycles(5);
    clr = 1'b0; cycles(3);
    lock_in = 1'b1; cycles(TMO + 5);
    chk("R10 no timeout after lock", tmo, 0);

    // PLL mode unlocked at release: reference cut and timeout (R9 R10)
    do_reset(3'b111, 1'b0);
    cycles(TMO + 6);
    chk("R10 timeout", tmo, 1);
    lock_in = 1'b1; cycles(6);
    chk("R9 cut stays", ref_conn, 0);
    chk("R6 lock seen", lock_s, 1);

    // PLL mode locked throughout, strap 101 (R4 R9)
    do_reset(3'b101, 1'b1);
    cycles(10);
    chk("R9 reference kept", ref_conn, 1);
    @(negedge clk); rst_n = 1'b0; cycles(3);
    chk("R11 quiet in reset", clk_en, 0);
    armed = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule